// File: doc/BRIEF.md
# Synchronous SRAM Sleep Sequencer

This block sits in front of a synchronous SRAM array and manages its low-power sleep state. A sleep request arrives asynchronously, passes through a synchronizer, and starts an entry sequence that takes a fixed number of clock cycles. From the first entry cycle the access gate closes, so chip enables and address strobes no longer reach the array. Once entry has begun it runs to completion, even if the request has already gone away.

When the request falls, the block runs an exit sequence of fixed length. A recovery window follows the exit sequence. During both the exit sequence and the recovery window the system must keep every enable and strobe inactive. The gate reopens only after the recovery window ends.

An access that is pending at the moment of entry is dropped and reported. A request made while the chip is fully selected is reported as a protocol error. Any enable or strobe seen during exit or recovery is also reported as an error. The block never touches the array contents: it only withholds control signals, so the stored data stay intact.

Top module: `sram_sleep_seq`

## Requirements
- R1: After reset `gate_open_o` is 1, and `asleep_o`, `drop_o` and `err_o` are 0.
- R2: `sleep_req_i` passes through SYNC_STAGES flops. If the request is first high at clock edge 1, the entry decision is taken at edge SYNC_STAGES+1, and `gate_open_o` falls after that edge.
- R3: Entry lasts ENTER_CYC cycles. `asleep_o` rises ENTER_CYC edges after the gate closes. `asleep_o` is never 1 while the gate is open.
- R4: After the synchronized request falls, `asleep_o` falls on the next edge. EXIT_CYC exit cycles and then REC_CYC recovery cycles follow. `gate_open_o` returns to 1 exactly EXIT_CYC+REC_CYC edges after `asleep_o` falls.
- R5: While the gate is closed, `ce_o`, `adsp_o` and `adsc_o` are forced to 0. While it is open, they equal `ce_i`, `adsp_i` and `adsc_i`.
- R6: If `pend_i` is 1 at the entry decision edge, `drop_o` is 1 for exactly the following cycle.
- R7: If every bit of `ce_i` is 1 at the entry decision edge, `err_o[0]` is 1 for the following cycle.
- R8: During exit or recovery, each edge that sees any `ce_i` bit, `adsp_i` or `adsc_i` high sets `err_o[1]` to 1 for the following cycle.
- R9: A request that the synchronizer sees for a single cycle still completes a full entry. `asleep_o` is then 1 for exactly one cycle before exit begins.
- R10: Enables and strobes driven while `asleep_o` is 1 raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Asynchronous sleep request |
| ce_i | input | NUM_CE | Active-high chip enables from the system |
| adsp_i | input | 1 | Processor address strobe, active high |
| adsc_i | input | 1 | Controller address strobe, active high |
| pend_i | input | 1 | An access is pending |
| ce_o | output | NUM_CE | Gated chip enables to the array |
| adsp_o | output | 1 | Gated processor strobe |
| adsc_o | output | 1 | Gated controller strobe |
| gate_open_o | output | 1 | 1 when accesses may reach the array |
| asleep_o | output | 1 | 1 while in the sleep state |
| drop_o | output | 1 | Pending access dropped at entry |
| err_o | output | 2 | bit0 selected at request, bit1 recovery violation |

## Verification
The bench targets the exact cycle on which the gate closes, sleep is reached, sleep is left and the gate reopens. A design with one synchronizer stage too few or too many, or an off-by-one entry or recovery counter, moves one of those edges and is caught. A one-cycle request checks that entry cannot abort; a design that bailed out of entry would never report sleep. Strobes are driven during sleep, during exit and during recovery, and also together with a pending access at the entry edge. These cases separate a design that flags errors in the wrong states, or fails to drop the pending access, from a correct one.

// File: rtl/sleep_seq_pkg.sv
`timescale 1ns/1ps
package sleep_seq_pkg;
   typedef enum logic [2:0] {
      ST_AWAKE   = 3'd0,
      ST_ENTER   = 3'd1,
      ST_SLEEP   = 3'd2,
      ST_EXIT    = 3'd3,
      ST_RECOVER = 3'd4
   } slp_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/sleep_sync.sv
`timescale 1ns/1ps
module sleep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
`timescale 1ns/1ps
module sleep_fsm
   import sleep_seq_pkg::*;
#(
   parameter int ENTER_CYC = 2,
   parameter int EXIT_CYC  = 2,
   parameter int REC_CYC   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s_i,
   output slp_state_t state_o,
   output logic       entry_evt_o
);
   localparam int MAXC  = max3(ENTER_CYC, EXIT_CYC, REC_CYC);
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CNT_W-1:0] ENT_LD = CNT_W'(ENTER_CYC - 1);
   localparam logic [CNT_W-1:0] EXT_LD = CNT_W'(EXIT_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

   slp_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_AWAKE: begin
            if (req_s_i) begin
               st_d  = ST_ENTER;
               cnt_d = ENT_LD;
            end
         end
         ST_ENTER: begin
            if (cnt_zero) st_d = ST_SLEEP;
            else          cnt_d = cnt_q - 1'b1;
         end
         ST_SLEEP: begin
            if (!req_s_i) begin
               st_d  = ST_EXIT;
               cnt_d = EXT_LD;
            end
         end
         ST_EXIT: begin
            if (cnt_zero) begin
               st_d  = ST_RECOVER;
               cnt_d = REC_LD;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_RECOVER: begin
            if (cnt_zero) st_d = ST_AWAKE;
            else          cnt_d = cnt_q - 1'b1;
         end
         default: begin
            st_d  = ST_AWAKE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_AWAKE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o     = st_q;
   assign entry_evt_o = (st_q == ST_AWAKE) && req_s_i;
endmodule

// File: rtl/sleep_guard.sv
`timescale 1ns/1ps
module sleep_guard
   import sleep_seq_pkg::*;
#(
   parameter int NUM_CE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slp_state_t        state_i,
   input  logic              entry_evt_i,
   input  logic [NUM_CE-1:0] ce_i,
   input  logic              adsp_i,
   input  logic              adsc_i,
   input  logic              pend_i,
   output logic [NUM_CE-1:0] ce_o,
   output logic              adsp_o,
   output logic              adsc_o,
   output logic              gate_open_o,
   output logic              drop_o,
   output logic [1:0]        err_o
);
   logic       open_w;
   logic       in_window;
   logic       any_active;
   logic       selected;
   logic       drop_q;
   logic [1:0] err_q;

   assign open_w     = (state_i == ST_AWAKE);
   assign in_window  = (state_i == ST_EXIT) || (state_i == ST_RECOVER);
   assign any_active = (|ce_i) | adsp_i | adsc_i;
   assign selected   = &ce_i;

   generate
      for (genvar g = 0; g < NUM_CE; g++) begin : g_ce_gate
         assign ce_o[g] = ce_i[g] & open_w;
      end
   endgenerate

   assign adsp_o = adsp_i & open_w;
   assign adsc_o = adsc_i & open_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_q <= 1'b0;
         err_q  <= 2'b00;
      end else begin
         drop_q   <= entry_evt_i & pend_i;
         err_q[0] <= entry_evt_i & selected;
         err_q[1] <= in_window & any_active;
      end
   end

   assign gate_open_o = open_w;
   assign drop_o      = drop_q;
   assign err_o       = err_q;
endmodule

// File: rtl/sram_sleep_seq.sv
`timescale 1ns/1ps
module sram_sleep_seq
   import sleep_seq_pkg::*;
#(
   parameter int NUM_CE      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ENTER_CYC   = 2,
   parameter int EXIT_CYC    = 2,
   parameter int REC_CYC     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req_i,
   input  logic [NUM_CE-1:0] ce_i,
   input  logic              adsp_i,
   input  logic              adsc_i,
   input  logic              pend_i,
   output logic [NUM_CE-1:0] ce_o,
   output logic              adsp_o,
   output logic              adsc_o,
   output logic              gate_open_o,
   output logic              asleep_o,
   output logic              drop_o,
   output logic [1:0]        err_o
);
   generate
      if (NUM_CE < 1) begin : g_bad_ce
         $error("NUM_CE must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ENTER_CYC < 1 || EXIT_CYC < 1 || REC_CYC < 1) begin : g_bad_cyc
         $error("phase lengths must be at least 1");
      end
   endgenerate

   logic       req_s;
   logic       entry_evt;
   slp_state_t state;

   sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sleep_req_i),
      .q_o   (req_s)
   );

   sleep_fsm #(
      .ENTER_CYC (ENTER_CYC),
      .EXIT_CYC  (EXIT_CYC),
      .REC_CYC   (REC_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_s_i     (req_s),
      .state_o     (state),
      .entry_evt_o (entry_evt)
   );

   sleep_guard #(.NUM_CE(NUM_CE)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .entry_evt_i (entry_evt),
      .ce_i        (ce_i),
      .adsp_i      (adsp_i),
      .adsc_i      (adsc_i),
      .pend_i      (pend_i),
      .ce_o        (ce_o),
      .adsp_o      (adsp_o),
      .adsc_o      (adsc_o),
      .gate_open_o (gate_open_o),
      .drop_o      (drop_o),
      .err_o       (err_o)
   );

   assign asleep_o = (state == ST_SLEEP);
endmodule

// File: rtl/sram_sleep_seq_chk.sv
`timescale 1ns/1ps
module sram_sleep_seq_chk #(
   parameter int NUM_CE = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CE-1:0] ce_i,
   input logic              adsp_i,
   input logic              adsc_i,
   input logic              pend_i,
   input logic [NUM_CE-1:0] ce_o,
   input logic              adsp_o,
   input logic              adsc_o,
   input logic              gate_open_o,
   input logic              asleep_o,
   input logic              drop_o,
   input logic [1:0]        err_o
);
   assert_asleep_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_o |-> !gate_open_o);

   assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_open_o |-> (ce_o == '0 && !adsp_o && !adsc_o));

   assert_reopen_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_open_o) |-> !$past(asleep_o));

   assert_drop_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> ($past(pend_i) && $past(gate_open_o)));

   assert_drop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |=> !drop_o);

   assert_sel_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o[0] |-> $past(&ce_i));

   assert_window_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o[1] |-> ($past((|ce_i) | adsp_i | adsc_i) && !$past(gate_open_o) && !$past(asleep_o)));

   assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_open_o) |=> !gate_open_o);
endmodule

bind sram_sleep_seq sram_sleep_seq_chk #(.NUM_CE(NUM_CE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_i        (ce_i),
   .adsp_i      (adsp_i),
   .adsc_i      (adsc_i),
   .pend_i      (pend_i),
   .ce_o        (ce_o),
   .adsp_o      (adsp_o),
   .adsc_o      (adsc_o),
   .gate_open_o (gate_open_o),
   .asleep_o    (asleep_o),
   .drop_o      (drop_o),
   .err_o       (err_o)
);

// File: tb/tb_sram_sleep_seq.sv
`timescale 1ns/1ps
module tb_sram_sleep_seq;
   localparam int NCE = 3;
   localparam int S   = 2;
   localparam int E   = 2;
   localparam int X   = 2;
   localparam int R   = 4;

   typedef struct {
      int         cyc;
      logic       gate;
      logic       asleep;
      logic       drop;
      logic [1:0] err;
      string      tag;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sleep_req_i = 1'b0;
   logic [NCE-1:0] ce_i = '0;
   logic           adsp_i = 1'b0;
   logic           adsc_i = 1'b0;
   logic           pend_i = 1'b0;
   logic [NCE-1:0] ce_o;
   logic           adsp_o, adsc_o, gate_open_o, asleep_o, drop_o;
   logic [1:0]     err_o;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   sram_sleep_seq #(
      .NUM_CE(NCE), .SYNC_STAGES(S), .ENTER_CYC(E), .EXIT_CYC(X), .REC_CYC(R)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .ce_i(ce_i),
      .adsp_i(adsp_i), .adsc_i(adsc_i), .pend_i(pend_i), .ce_o(ce_o),
      .adsp_o(adsp_o), .adsc_o(adsc_o), .gate_open_o(gate_open_o),
      .asleep_o(asleep_o), .drop_o(drop_o), .err_o(err_o)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(input int c, input logic g, input logic a, input logic d,
                       input logic [1:0] e, input string t);
      exp_t it;
      it.cyc = c; it.gate = g; it.asleep = a; it.drop = d; it.err = e; it.tag = t;
      sb_q.push_back(it);
   endtask

   task automatic check(input bit ok, input string t, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: compares registered outputs against the scoreboard
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
         exp_t it;
         it = sb_q.pop_front();
         if (it.cyc < cyc) begin
            check(1'b0, {it.tag, " (missed cycle)"}, cyc, it.cyc);
         end else begin
            check({gate_open_o, asleep_o, drop_o, err_o} == {it.gate, it.asleep, it.drop, it.err},
                  it.tag, int'({gate_open_o, asleep_o, drop_o, err_o}),
                  int'({it.gate, it.asleep, it.drop, it.err}));
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c0, c1, t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({gate_open_o, asleep_o, drop_o, err_o} == 5'b10000, "R1 reset state",
            int'({gate_open_o, asleep_o, drop_o, err_o}), 16);

      // R5 pass-through while awake
      adsp_i = 1'b1; ce_i = 3'b101; #1;
      check(adsp_o == 1'b1 && ce_o == 3'b101, "R5 pass when open", int'({ce_o, adsp_o}), 11);
      adsp_i = 1'b0; ce_i = '0;
      @(negedge clk);

      // R2, R3 clean entry
      c0 = cyc;
      sleep_req_i = 1'b1;
      push(c0+S,       1'b1, 1'b0, 1'b0, 2'b00, "R2 gate still open");
      push(c0+S+1,     1'b0, 1'b0, 1'b0, 2'b00, "R2 gate closes");
      push(c0+S+E,     1'b0, 1'b0, 1'b0, 2'b00, "R3 not yet asleep");
      push(c0+S+1+E,   1'b0, 1'b1, 1'b0, 2'b00, "R3 asleep");
      wait_cyc(c0+S+1+E+2);

      // R5 blocked and R10 no error while asleep
      ce_i = '1; adsp_i = 1'b1; adsc_i = 1'b1; #1;
      check(ce_o == '0 && !adsp_o && !adsc_o, "R5 blocked when asleep",
            int'({ce_o, adsp_o, adsc_o}), 0);
      push(cyc+1, 1'b0, 1'b1, 1'b0, 2'b00, "R10 no error asleep");
      push(cyc+2, 1'b0, 1'b1, 1'b0, 2'b00, "R10 no error asleep");
      wait_cyc(cyc+3);
      ce_i = '0; adsp_i = 1'b0; adsc_i = 1'b0;
      @(negedge clk);

      // R4 exit with an R8 violation in recovery
      c1 = cyc;
      sleep_req_i = 1'b0;
      push(c1+S,       1'b0, 1'b1, 1'b0, 2'b00, "R4 still asleep");
      push(c1+S+1,     1'b0, 1'b0, 1'b0, 2'b00, "R4 asleep falls");
      push(c1+S+2+X,   1'b0, 1'b0, 1'b0, 2'b10, "R8 strobe in recovery");
      push(c1+S+3+X,   1'b0, 1'b0, 1'b0, 2'b00, "R8 error clears");
      push(c1+S+X+R,   1'b0, 1'b0, 1'b0, 2'b00, "R4 still closed");
      push(c1+S+1+X+R, 1'b1, 1'b0, 1'b0, 2'b00, "R4 gate reopens");
      wait_cyc(c1+S+1+X);
      adsp_i = 1'b1;
      @(negedge clk);
      adsp_i = 1'b0;
      wait_cyc(c1+S+X+R+4);

      // R6, R7 selected with pending access at request
      c0 = cyc;
      ce_i = '1; pend_i = 1'b1; sleep_req_i = 1'b1;
      push(c0+S+1,   1'b0, 1'b0, 1'b1, 2'b01, "R6 R7 drop and select error");
      push(c0+S+2,   1'b0, 1'b0, 1'b0, 2'b00, "R6 drop is one pulse");
      push(c0+S+1+E, 1'b0, 1'b1, 1'b0, 2'b00, "R3 asleep after select");
      wait_cyc(c0+S+1);
      ce_i = '0; pend_i = 1'b0;
      wait_cyc(c0+S+1+E+2);
      c1 = cyc;
      sleep_req_i = 1'b0;
      push(c1+S+1+X+R, 1'b1, 1'b0, 1'b0, 2'b00, "R4 clean wake");
      wait_cyc(c1+S+1+X+R+3);

      // R9 one-cycle request, R8 violation during exit
      c0 = cyc;
      sleep_req_i = 1'b1;
      @(negedge clk);
      sleep_req_i = 1'b0;
      t = c0 + S + 1 + E;
      push(c0+S+1, 1'b0, 1'b0, 1'b0, 2'b00, "R9 entry starts");
      push(t-1,    1'b0, 1'b0, 1'b0, 2'b00, "R9 entering");
      push(t,      1'b0, 1'b1, 1'b0, 2'b00, "R9 asleep one cycle");
      push(t+1,    1'b0, 1'b0, 1'b0, 2'b00, "R9 exit begins");
      push(t+2,    1'b0, 1'b0, 1'b0, 2'b10, "R8 enable in exit");
      push(t+3,    1'b0, 1'b0, 1'b0, 2'b00, "R8 error clears");
      push(t+X+R,  1'b0, 1'b0, 1'b0, 2'b00, "R9 still closed");
      push(t+1+X+R,1'b1, 1'b0, 1'b0, 2'b00, "R9 gate reopens");
      wait_cyc(t+1);
      ce_i = 3'b010;
      @(negedge clk);
      ce_i = '0;
      wait_cyc(t+X+R+4);

      if (sb_q.size() != 0) check(1'b0, "scoreboard drained", sb_q.size(), 0);
      finish_run();
   end
endmodule